// File: doc/BRIEF.md
# Strided Copy Job Launcher

This block is the software-facing front of a copy engine that moves rectangular (strided) memory regions. Software fills a set of 64-bit registers with source and destination addresses, a byte count, a per-row stride for each side, a row repetition count and three option flags. It then reads a launch register. That read turns the current register contents into a job descriptor and places the descriptor in a small queue. The backend drains the queue through a valid/ready handshake.

Each accepted job receives a nonzero transfer number, and the launch read returns that number. A launch that cannot be accepted returns 0. The backend returns one completion pulse per job, in launch order. The block counts these pulses into a completion register. Software polls that register until it shows the number it was given at launch. A status register reports whether any job is still outstanding.

Register bus: a request is one cycle of `reg_valid_i`, with `reg_write_i` choosing write or read. Read data appears on `reg_rdata_o` in the following cycle, qualified by `reg_rvalid_o`. Register index is `reg_addr_i >> 3`. Map (byte offsets): 0x00 source, 0x08 destination, 0x10 byte count, 0x18 options, 0x20 status, 0x28 launch, 0x30 completed number, 0x38 source stride, 0x40 destination stride, 0x48 repetitions.

Top module: `dma2d_fe`

## Requirements
- R1: After reset every storage register reads 0, the status and completed-number registers read 0, and no job is offered to the backend.
- R2: A write to source, destination, byte count, options, either stride or repetitions stores all 64 bits. A later read returns them unchanged. Read data and `reg_rvalid_o` appear exactly one cycle after the read request.
- R3: Writes to status (0x20), launch (0x28) and completed number (0x30) change nothing and launch nothing. A read at an address that is unmapped or not a multiple of 8 returns 0.
- R4: A read of 0x28 with a nonzero byte count and a non-full queue enqueues a job. The read returns the job's number. Numbers start at 1 and grow by one per accepted launch.
- R5: The descriptor carries source, destination, byte count, repetitions and the job number. It also carries option bits taken from options register bits [2:0], in this order: bit 0 decouple, bit 1 deburst, bit 2 serialize.
- R6: When repetitions is 0 the descriptor carries both strides as 0 (a plain linear copy). Otherwise it carries the register strides.
- R7: A launch read returns 0 and enqueues nothing when the byte count is 0, or when the queue holds QUEUE_DEPTH entries at the read. This holds even if the backend takes a job in that same cycle. A rejected launch consumes no number.
- R8: The queue holds QUEUE_DEPTH (default 2) jobs and presents them in launch order. An offered job stays stable until `job_ready_i` is seen high with `job_valid_o`.
- R9: Each `done_pulse_i` while a job is outstanding advances the completed number by one. A pulse while nothing is outstanding is ignored.
- R10: Status bit 0 (busy) reads 1 exactly when the completed number differs from the last issued number. Bits [63:1] read 0.
- R11: Job numbers and the completed number wrap from 2^ID_W-1 to 1, never taking the value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register request strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 64 | Write data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| reg_rdata_o | output | 64 | Read data |
| job_valid_o | output | 1 | A descriptor is offered |
| job_ready_i | input | 1 | Backend takes the descriptor |
| job_id_o | output | ID_W | Job number |
| job_src_o | output | 64 | Source address |
| job_dst_o | output | 64 | Destination address |
| job_len_o | output | 64 | Bytes per row |
| job_src_stride_o | output | 64 | Source row stride |
| job_dst_stride_o | output | 64 | Destination row stride |
| job_reps_o | output | 64 | Row repetitions |
| job_opts_o | output | 3 | Option flags: decouple, deburst, serialize |
| done_pulse_i | input | 1 | One-cycle completion of the oldest outstanding job |

## Verification
The hardest situation to reach is a launch read that arrives while the queue is full and the backend accepts the head job in that very cycle. The read must still be rejected, and the freed slot must stay empty. The stimulus stalls the backend until two jobs are queued, then raises `job_ready_i` in the same cycle as the launch read. Number wraparound needs 2^ID_W-1 accepted launches. The stimulus gets there with a backend that is always ready and a completion pulse after every launch, then checks the number returned just past the wrap.

// File: rtl/dma2d_fe_pkg.sv
package dma2d_fe_pkg;

  localparam int unsigned REG_W    = 64;
  localparam int unsigned NUM_OPTS = 3;

  localparam int unsigned OPT_DECOUPLE  = 0;
  localparam int unsigned OPT_DEBURST   = 1;
  localparam int unsigned OPT_SERIALIZE = 2;

  localparam logic [7:0] OFF_LAUNCH = 8'h28;

  typedef enum logic [3:0] {
    SEL_SRC   = 4'd0,
    SEL_DST   = 4'd1,
    SEL_LEN   = 4'd2,
    SEL_OPTS  = 4'd3,
    SEL_STAT  = 4'd4,
    SEL_LNCH  = 4'd5,
    SEL_DONE  = 4'd6,
    SEL_SSTR  = 4'd7,
    SEL_DSTR  = 4'd8,
    SEL_REPS  = 4'd9,
    SEL_NONE  = 4'd15
  } reg_sel_e;

  typedef struct packed {
    logic [REG_W-1:0]    src;
    logic [REG_W-1:0]    dst;
    logic [REG_W-1:0]    len;
    logic [REG_W-1:0]    src_stride;
    logic [REG_W-1:0]    dst_stride;
    logic [REG_W-1:0]    reps;
    logic [NUM_OPTS-1:0] opts;
  } job_desc_t;

endpackage

// File: rtl/dma2d_fe_regs.sv
module dma2d_fe_regs
  import dma2d_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output job_desc_t        desc_o,
  output logic             len_zero_o
);

  logic [REG_W-1:0] src_q, dst_q, len_q, opts_q, sstr_q, dstr_q, reps_q;
  logic             flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      opts_q <= '0;
      sstr_q <= '0;
      dstr_q <= '0;
      reps_q <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_SRC:  src_q  <= wdata_i;
        SEL_DST:  dst_q  <= wdata_i;
        SEL_LEN:  len_q  <= wdata_i;
        SEL_OPTS: opts_q <= wdata_i;
        SEL_SSTR: sstr_q <= wdata_i;
        SEL_DSTR: dstr_q <= wdata_i;
        SEL_REPS: reps_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_SRC:  rdata_o = src_q;
      SEL_DST:  rdata_o = dst_q;
      SEL_LEN:  rdata_o = len_q;
      SEL_OPTS: rdata_o = opts_q;
      SEL_SSTR: rdata_o = sstr_q;
      SEL_DSTR: rdata_o = dstr_q;
      SEL_REPS: rdata_o = reps_q;
      default:  rdata_o = '0;
    endcase
  end

  // zero repetitions: linear copy, strides carry no meaning
  assign flat = (reps_q == '0);

  always_comb begin
    desc_o            = '0;
    desc_o.src        = src_q;
    desc_o.dst        = dst_q;
    desc_o.len        = len_q;
    desc_o.reps       = reps_q;
    desc_o.src_stride = flat ? '0 : sstr_q;
    desc_o.dst_stride = flat ? '0 : dstr_q;
    desc_o.opts[OPT_DECOUPLE]  = opts_q[OPT_DECOUPLE];
    desc_o.opts[OPT_DEBURST]   = opts_q[OPT_DEBURST];
    desc_o.opts[OPT_SERIALIZE] = opts_q[OPT_SERIALIZE];
  end

  assign len_zero_o = (len_q == '0);

endmodule

// File: rtl/dma2d_fe_ids.sv
module dma2d_fe_ids #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic            done_pulse_i,
  output logic [ID_W-1:0] next_id_o,
  output logic [ID_W-1:0] last_id_o,
  output logic [ID_W-1:0] done_id_o,
  output logic            busy_o
);

  localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

  logic [ID_W-1:0] last_q, done_q;

  function automatic logic [ID_W-1:0] step(input logic [ID_W-1:0] v);
    return (v == '1) ? ID_ONE : v + ID_ONE;
  endfunction

  assign next_id_o = step(last_q);
  assign busy_o    = (last_q != done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      done_q <= '0;
    end else begin
      if (launch_i) last_q <= next_id_o;
      if (done_pulse_i && busy_o) done_q <= step(done_q);
    end
  end

  assign last_id_o = last_q;
  assign done_id_o = done_q;

endmodule

// File: rtl/dma2d_fe_fifo.sv
module dma2d_fe_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o && ready_i;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (push_i && wr_q == PTR_W'(i)) mem_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= adv(wr_q);
      if (pop)    rd_q <= adv(rd_q);
      if (push_i && !pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/dma2d_fe.sv
module dma2d_fe
  import dma2d_fe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned ID_W        = 8,
  parameter int unsigned QUEUE_DEPTH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_valid_i,
  input  logic                reg_write_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic                reg_rvalid_o,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                job_valid_o,
  input  logic                job_ready_i,
  output logic [ID_W-1:0]     job_id_o,
  output logic [REG_W-1:0]    job_src_o,
  output logic [REG_W-1:0]    job_dst_o,
  output logic [REG_W-1:0]    job_len_o,
  output logic [REG_W-1:0]    job_src_stride_o,
  output logic [REG_W-1:0]    job_dst_stride_o,
  output logic [REG_W-1:0]    job_reps_o,
  output logic [NUM_OPTS-1:0] job_opts_o,
  input  logic                done_pulse_i
);

  localparam int unsigned IDX_W  = ADDR_W - 3;
  localparam int unsigned DESC_W = $bits(job_desc_t);
  localparam int unsigned ENTRY_W = DESC_W + ID_W;

  reg_sel_e         sel;
  logic             rd_req, wr_req, launch_req, accept;
  logic [IDX_W-1:0] word_idx;
  logic [REG_W-1:0] cfg_rdata, rdata_d, rdata_q;
  logic             rvalid_q;
  job_desc_t        cur_desc, head_desc;
  logic             len_zero, q_full;
  logic [ID_W-1:0]  next_id, last_id_q, done_id_q, head_id;
  logic             busy;
  logic [ENTRY_W-1:0] head_entry;
  logic [REG_W-1:0] len_q;

  assign word_idx = reg_addr_i[ADDR_W-1:3];

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr_i[2:0] == 3'b000) begin
      unique case (word_idx)
        IDX_W'(0): sel = SEL_SRC;
        IDX_W'(1): sel = SEL_DST;
        IDX_W'(2): sel = SEL_LEN;
        IDX_W'(3): sel = SEL_OPTS;
        IDX_W'(4): sel = SEL_STAT;
        IDX_W'(5): sel = SEL_LNCH;
        IDX_W'(6): sel = SEL_DONE;
        IDX_W'(7): sel = SEL_SSTR;
        IDX_W'(8): sel = SEL_DSTR;
        IDX_W'(9): sel = SEL_REPS;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  assign rd_req     = reg_valid_i && !reg_write_i;
  assign wr_req     = reg_valid_i && reg_write_i;
  assign launch_req = rd_req && (sel == SEL_LNCH);
  // full is judged on the pre-edge count; a same-cycle pop does not free a slot
  assign accept     = launch_req && !len_zero && !q_full;

  dma2d_fe_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_req),
    .sel_i      (sel),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (cfg_rdata),
    .desc_o     (cur_desc),
    .len_zero_o (len_zero)
  );

  assign len_q = cur_desc.len;

  dma2d_fe_ids #(.ID_W(ID_W)) u_ids (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (accept),
    .done_pulse_i (done_pulse_i),
    .next_id_o    (next_id),
    .last_id_o    (last_id_q),
    .done_id_o    (done_id_q),
    .busy_o       (busy)
  );

  dma2d_fe_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .data_i  ({next_id, cur_desc}),
    .full_o  (q_full),
    .valid_o (job_valid_o),
    .ready_i (job_ready_i),
    .data_o  (head_entry)
  );

  assign head_id   = head_entry[ENTRY_W-1:DESC_W];
  assign head_desc = head_entry[DESC_W-1:0];

  assign job_id_o         = head_id;
  assign job_src_o        = head_desc.src;
  assign job_dst_o        = head_desc.dst;
  assign job_len_o        = head_desc.len;
  assign job_src_stride_o = head_desc.src_stride;
  assign job_dst_stride_o = head_desc.dst_stride;
  assign job_reps_o       = head_desc.reps;
  assign job_opts_o       = head_desc.opts;

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_d = REG_W'(busy);
      SEL_LNCH: rdata_d = accept ? REG_W'(next_id) : '0;
      SEL_DONE: rdata_d = REG_W'(done_id_q);
      default:  rdata_d = cfg_rdata;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign reg_rvalid_o = rvalid_q;
  assign reg_rdata_o  = rdata_q;

endmodule

// File: rtl/dma2d_fe_chk.sv
module dma2d_fe_chk
  import dma2d_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned ID_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_valid_i,
  input logic              reg_write_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_rvalid_o,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              job_valid_o,
  input logic              job_ready_i,
  input logic [ID_W-1:0]   job_id_o,
  input logic [REG_W-1:0]  job_reps_o,
  input logic [REG_W-1:0]  job_src_stride_o,
  input logic [REG_W-1:0]  job_dst_stride_o,
  input logic              done_pulse_i,
  input logic [ID_W-1:0]   done_id_q,
  input logic [ID_W-1:0]   last_id_q,
  input logic [REG_W-1:0]  len_q
);

  localparam logic [ADDR_W-1:0] LAUNCH_ADDR = ADDR_W'(OFF_LAUNCH);

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_i && !reg_write_i |=> reg_rvalid_o); // R2

  AST_JOB_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o && !job_ready_i |=> job_valid_o && $stable(job_id_o)); // R8

  AST_FLAT_STRIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o && job_reps_o == '0 |-> job_src_stride_o == '0 && job_dst_stride_o == '0); // R6

  AST_ZERO_LEN_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_i && !reg_write_i && reg_addr_i == LAUNCH_ADDR && len_q == '0
    |=> reg_rdata_o == '0); // R7

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_pulse_i |=> $stable(done_id_q)); // R9

  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_id_q == last_id_q |-> !job_valid_o); // R10

  AST_ID_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o |-> job_id_o != '0); // R11

endmodule

bind dma2d_fe dma2d_fe_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .reg_valid_i      (reg_valid_i),
  .reg_write_i      (reg_write_i),
  .reg_addr_i       (reg_addr_i),
  .reg_rvalid_o     (reg_rvalid_o),
  .reg_rdata_o      (reg_rdata_o),
  .job_valid_o      (job_valid_o),
  .job_ready_i      (job_ready_i),
  .job_id_o         (job_id_o),
  .job_reps_o       (job_reps_o),
  .job_src_stride_o (job_src_stride_o),
  .job_dst_stride_o (job_dst_stride_o),
  .done_pulse_i     (done_pulse_i),
  .done_id_q        (done_id_q),
  .last_id_q        (last_id_q),
  .len_q            (len_q)
);

// File: tb/dma2d_fe_tb.sv
module dma2d_fe_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 7;
  localparam int ID_W   = 8;
  localparam int DEPTH  = 2;
  localparam int ID_MAX = (1 << ID_W) - 1;
  localparam int WATCHDOG = 150000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_valid_i = 1'b0;
  logic              reg_write_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [63:0]       reg_wdata_i = '0;
  logic              reg_rvalid_o;
  logic [63:0]       reg_rdata_o;
  logic              job_valid_o;
  logic              job_ready_i = 1'b0;
  logic [ID_W-1:0]   job_id_o;
  logic [63:0]       job_src_o, job_dst_o, job_len_o, job_src_stride_o, job_dst_stride_o, job_reps_o;
  logic [2:0]        job_opts_o;
  logic              done_pulse_i = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dma2d_fe #(.ADDR_W(ADDR_W), .ID_W(ID_W), .QUEUE_DEPTH(DEPTH)) u_dut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    int unsigned id;
    logic [63:0] src, dst, len, ss, ds, reps;
    logic [2:0]  opts;
  } mjob_t;

  logic [63:0] m_src, m_dst, m_len, m_opts, m_ss, m_ds, m_reps;
  int unsigned m_last, m_done;
  mjob_t       m_q[$];
  bit          m_rvalid;
  logic [63:0] m_rdata;
  string       m_tag;

  function automatic int unsigned id_step(input int unsigned v);
    return (v == ID_MAX) ? 1 : v + 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_src = 0; m_dst = 0; m_len = 0; m_opts = 0; m_ss = 0; m_ds = 0; m_reps = 0;
      m_last = 0; m_done = 0; m_q.delete(); m_rvalid = 0; m_rdata = 0; m_tag = "R1";
    end else begin
      bit rd, wr, acc, aligned;
      int idx;
      mjob_t j;
      rd = reg_valid_i && !reg_write_i;
      wr = reg_valid_i && reg_write_i;
      aligned = (reg_addr_i[2:0] == 3'b0);
      idx = aligned ? int'(reg_addr_i >> 3) : 99;
      acc = rd && idx == 5 && m_len != 0 && m_q.size() < DEPTH;
      m_rvalid = rd;
      if (rd) begin
        case (idx)
          0: begin m_rdata = m_src;  m_tag = "R2"; end
          1: begin m_rdata = m_dst;  m_tag = "R2"; end
          2: begin m_rdata = m_len;  m_tag = "R2"; end
          3: begin m_rdata = m_opts; m_tag = "R2"; end
          4: begin m_rdata = {63'b0, m_last != m_done}; m_tag = "R10"; end
          5: begin m_rdata = acc ? 64'(id_step(m_last)) : 64'd0; m_tag = acc ? "R4" : "R7"; end
          6: begin m_rdata = 64'(m_done); m_tag = "R9"; end
          7: begin m_rdata = m_ss;   m_tag = "R2"; end
          8: begin m_rdata = m_ds;   m_tag = "R2"; end
          9: begin m_rdata = m_reps; m_tag = "R2"; end
          default: begin m_rdata = 0; m_tag = "R3"; end
        endcase
      end
      if (m_q.size() > 0 && job_ready_i) void'(m_q.pop_front());
      if (done_pulse_i && m_done != m_last) m_done = id_step(m_done);
      if (acc) begin
        m_last = id_step(m_last);
        j.id = m_last; j.src = m_src; j.dst = m_dst; j.len = m_len; j.reps = m_reps;
        j.ss = (m_reps == 0) ? 64'd0 : m_ss;
        j.ds = (m_reps == 0) ? 64'd0 : m_ds;
        j.opts = m_opts[2:0];
        m_q.push_back(j);
      end
      if (wr) begin
        case (idx)
          0: m_src  = reg_wdata_i;
          1: m_dst  = reg_wdata_i;
          2: m_len  = reg_wdata_i;
          3: m_opts = reg_wdata_i;
          7: m_ss   = reg_wdata_i;
          8: m_ds   = reg_wdata_i;
          9: m_reps = reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(reg_rvalid_o == m_rvalid, "R2 rvalid", 64'(reg_rvalid_o), 64'(m_rvalid));
      if (m_rvalid) chk(reg_rdata_o == m_rdata, m_tag, reg_rdata_o, m_rdata);
      chk(job_valid_o == (m_q.size() > 0), "R8 job_valid", 64'(job_valid_o), 64'(m_q.size() > 0));
      if (job_valid_o && m_q.size() > 0) begin
        chk(job_id_o == ID_W'(m_q[0].id), "R4 job_id", 64'(job_id_o), 64'(m_q[0].id));
        chk(job_src_o == m_q[0].src && job_dst_o == m_q[0].dst && job_len_o == m_q[0].len
            && job_reps_o == m_q[0].reps, "R5 descriptor", job_src_o, m_q[0].src);
        chk(job_opts_o == m_q[0].opts, "R5 opts", 64'(job_opts_o), 64'(m_q[0].opts));
        chk(job_src_stride_o == m_q[0].ss && job_dst_stride_o == m_q[0].ds, "R6 strides",
            job_src_stride_o, m_q[0].ss);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      report();
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 1; reg_addr_i = ADDR_W'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_valid_i = 0; reg_write_i = 0;
  endtask

  task automatic rd_exp(input int a, input logic [63:0] exp, input string tag);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 0; reg_addr_i = ADDR_W'(a);
    @(negedge clk_i);
    reg_valid_i = 0;
    chk(reg_rvalid_o && reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  task automatic pulse();
    @(negedge clk_i); done_pulse_i = 1;
    @(negedge clk_i); done_pulse_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset values
    for (int a = 0; a <= 'h48; a += 8)
      if (a != 'h28) rd_exp(a, 64'd0, "R1 reset read");
    chk(job_valid_o == 0, "R1 no job", 64'(job_valid_o), 64'd0);

    // R2 write / readback
    wr('h00, 64'h1111_2222_3333_4444);
    wr('h08, 64'h8000_0000_0000_1000);
    wr('h18, 64'hFFFF_0000_0000_0005);
    wr('h38, 64'h40);
    wr('h40, 64'h80);
    rd_exp('h00, 64'h1111_2222_3333_4444, "R2 src");
    rd_exp('h18, 64'hFFFF_0000_0000_0005, "R2 opts");
    rd_exp('h40, 64'h80, "R2 dst stride");

    // R3 ignored writes and unmapped reads
    wr('h28, 64'hFF); wr('h30, 64'h7); wr('h20, 64'h1);
    chk(job_valid_o == 0, "R3 launch write ignored", 64'(job_valid_o), 64'd0);
    rd_exp('h30, 64'd0, "R3 done write ignored");
    rd_exp('h20, 64'd0, "R3 status write ignored");
    rd_exp('h50, 64'd0, "R3 unmapped");
    rd_exp('h04, 64'd0, "R3 unaligned");

    // R7 zero length rejected, R4 first id
    job_ready_i = 0;
    rd_exp('h28, 64'd0, "R7 zero length");
    wr('h10, 64'd64);
    rd_exp('h28, 64'd1, "R4 first id");
    chk(job_src_stride_o == 0 && job_dst_stride_o == 0, "R6 flat strides", job_src_stride_o, 64'd0);
    chk(job_opts_o == 3'b101, "R5 opts bits", 64'(job_opts_o), 64'd5);
    wr('h48, 64'd3);
    rd_exp('h28, 64'd2, "R4 second id");
    rd_exp('h28, 64'd0, "R7 queue full");
    rd_exp('h20, 64'd1, "R10 busy");

    // R7 full queue with same-cycle pop still rejects
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 0; reg_addr_i = ADDR_W'('h28); job_ready_i = 1;
    @(negedge clk_i);
    reg_valid_i = 0; job_ready_i = 0;
    chk(reg_rdata_o == 0, "R7 full with pop", reg_rdata_o, 64'd0);
    chk(job_valid_o == 1 && job_id_o == 2, "R8 order", 64'(job_id_o), 64'd2);
    job_ready_i = 1;
    @(negedge clk_i);
    chk(job_valid_o == 0, "R8 drained", 64'(job_valid_o), 64'd0);

    // R9 completions
    pulse();
    rd_exp('h30, 64'd1, "R9 first done");
    pulse();
    rd_exp('h30, 64'd2, "R9 second done");
    rd_exp('h20, 64'd0, "R10 idle");
    pulse();
    rd_exp('h30, 64'd2, "R9 idle pulse ignored");

    // R11 wraparound: 300 more launches, 302 in total
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      reg_valid_i = 1; reg_write_i = 0; reg_addr_i = ADDR_W'('h28);
      @(negedge clk_i);
      reg_valid_i = 0; done_pulse_i = 1;
      if (k == 252) chk(reg_rdata_o == 64'(ID_MAX), "R11 max id", reg_rdata_o, 64'(ID_MAX));
      if (k == 253) chk(reg_rdata_o == 64'd1, "R11 wrap to 1", reg_rdata_o, 64'd1);
      @(negedge clk_i);
      done_pulse_i = 0;
    end
    rd_exp('h30, 64'd47, "R11 done after wrap");
    rd_exp('h20, 64'd0, "R10 idle after wrap");

    repeat (3) @(negedge clk_i);
    report();
  end

endmodule